// File: doc/BRIEF.md
# Two-Bank Flash Read-Status Multiplexer

This block sits on the read-data path of a flash array split into two banks. An external sequencer reports which operation is running (program, erase, erase-suspend, or program under suspend), the bank and the sector it targets, and bit 7 of the word being programmed. For each read strobe the block decides between two answers. If the address is outside the operation's scope, it returns the array word. Otherwise it returns a status word made of a data-polling bit, a toggle bit and a second, suspend-aware toggle bit. The block also drives a ready flag.

Software polls the same address over and over. Program completion shows as the first toggle bit no longer changing. An erase is told apart from a suspended erase by which toggle bits change. The array contents come from a fixed function of the address, so the array needs no storage.

Top module: `flash_status_mux`

## Requirements
- R1: While reset is asserted and after reset, `rdata_o` is 0 until the first read, both toggle states are 0, and `ready_o` is 1 while `op_i` is idle.
- R2: With `op_i` = 0 (idle), a read of address A returns `((A * 40503) ^ 16'h3C5A)[15:0]` on `rdata_o` one clock after the strobe. `rdata_o` holds its value in cycles with no strobe.
- R3: During any operation, a read whose bank bit (address bit 11) differs from `op_bank_i` returns array data and changes neither toggle state.
- R4: With `op_i` = 1 (program), a read in the busy bank returns bit 7 = NOT `prog_msb_i`. Bit 6 carries the primary toggle, which inverts after each such read. Bit 2 carries the secondary toggle, which holds.
- R5: With `op_i` = 2 (erase), a read in the busy bank returns bit 7 = 0. Bits 6 and 2 carry the two toggles, and both invert after each such read.
- R6: With `op_i` = 3 (erase suspended), a read in the busy bank whose sector field (address bits 10:7) equals `tgt_sect_i` returns bit 7 = 1 and bit 6 = 1. Bit 2 carries the secondary toggle, which inverts after each such read.
- R7: With `op_i` = 3, a read in the busy bank from any other sector returns array data and changes neither toggle.
- R8: With `op_i` = 4 (program during suspend), any read in the busy bank returns program status exactly as in R4.
- R9: `ready_o` is 0 when `op_i` is 1, 2 or 4, and 1 when `op_i` is 0 or 3, in the same cycle.
- R10: When `op_i` changes to 1, 2 or 4 from a different value, both toggles clear in that cycle. A status read in that same cycle returns bits 6 and 2 as 0 (bit 6 as 1 in suspend status).
- R11: In every status word, all bits other than 7, 6 and 2 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rd_i | input | 1 | Read strobe, one per read |
| rd_addr_i | input | ADDR_W (12) | Read address: bit 11 bank, bits 10:7 sector, bits 6:0 offset |
| op_i | input | 3 | Operation: 0 idle, 1 program, 2 erase, 3 erase suspended, 4 program during suspend |
| op_bank_i | input | 1 | Bank that holds the running operation |
| tgt_sect_i | input | SECT_W (4) | Sector targeted by the operation (the suspended sector in mode 3) |
| prog_msb_i | input | 1 | Bit 7 of the word being programmed |
| rdata_o | output | DATA_W (16) | Read data: array word or status word |
| ready_o | output | 1 | 1 = ready, 0 = busy |

## Verification
With the default registered output, the answer to a strobe appears on `rdata_o` one clock later. Toggle state also updates at that edge, so the next strobe sees the inverted value. The bench drives each stimulus at a falling edge and compares `rdata_o` at the next falling edge against a model advanced in step. `ready_o` depends only on the operation code, so it is checked a nanosecond after the code is applied, before any clock edge. Random operation changes mixed with reads in both banks and sectors exercise the clears on operation start and the reads that must leave the toggles alone.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

   typedef enum logic [2:0] {
      OP_IDLE      = 3'd0,
      OP_PROG      = 3'd1,
      OP_ERASE     = 3'd2,
      OP_SUSP      = 3'd3,
      OP_SUSP_PROG = 3'd4
   } op_e;

   typedef enum logic [1:0] {
      RK_DATA,
      RK_PROG,
      RK_ERASE,
      RK_SUSP
   } rkind_e;

   localparam int POLL_BIT = 7;
   localparam int TOG_BIT  = 6;
   localparam int TOG2_BIT = 2;
   localparam int N_TOG    = 2;

   // Fixed array contents: word depends only on the address.
   function automatic logic [31:0] array_word(input logic [31:0] addr);
      logic [31:0] mix;
      mix = (addr * 32'd40503) ^ 32'h0000_3C5A;
      return {16'h0000, mix[15:0]};
   endfunction

   function automatic logic op_is_busy(input op_e op);
      return (op == OP_PROG) || (op == OP_ERASE) || (op == OP_SUSP_PROG);
   endfunction

endpackage

// File: rtl/fs_toggle_bit.sv
module fs_toggle_bit (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic flip_i,
   output logic cur_o
);

   logic q;

   // Value seen by a read in this cycle: a clear takes effect at once.
   assign cur_o = clr_i ? 1'b0 : q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         q <= 1'b0;
      end else if (flip_i) begin
         q <= ~cur_o;
      end else begin
         q <= cur_o;
      end
   end

   // R4: a toggle that is neither flipped nor cleared keeps its state
   p_no_flip_hold_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flip_i && !clr_i) |=> $stable(q));

   // R10: a clear without a flip leaves the state at 0
   p_clear_zero_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !flip_i) |=> (q == 1'b0));

endmodule

// File: rtl/fs_read_classify.sv
module fs_read_classify
   import flash_stat_pkg::*;
#(
   parameter int SECT_W = 4
) (
   input  op_e               op_i,
   input  logic              rd_bank_i,
   input  logic [SECT_W-1:0] rd_sect_i,
   input  logic              op_bank_i,
   input  logic [SECT_W-1:0] tgt_sect_i,
   output rkind_e            kind_o
);

   logic in_bank;
   logic in_sect;

   assign in_bank = (rd_bank_i == op_bank_i);
   assign in_sect = (rd_sect_i == tgt_sect_i);

   always_comb begin
      kind_o = RK_DATA;
      if (in_bank) begin
         unique case (op_i)
            OP_PROG, OP_SUSP_PROG: kind_o = RK_PROG;
            OP_ERASE:              kind_o = RK_ERASE;
            OP_SUSP:               kind_o = in_sect ? RK_SUSP : RK_DATA;
            default:               kind_o = RK_DATA;
         endcase
      end
   end

endmodule

// File: rtl/flash_status_mux.sv
module flash_status_mux
   import flash_stat_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int SECT_W  = 4,
   parameter int DATA_W  = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic [2:0]        op_i,
   input  logic              op_bank_i,
   input  logic [SECT_W-1:0] tgt_sect_i,
   input  logic              prog_msb_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              ready_o
);

   localparam int BANK_BIT = ADDR_W - 1;
   localparam int OFF_W    = ADDR_W - 1 - SECT_W;

   initial begin
      assert (OFF_W >= 0) else $error("flash_status_mux: ADDR_W too small for SECT_W");
      assert (DATA_W >= 8 && DATA_W <= 32) else $error("flash_status_mux: DATA_W out of range");
   end

   op_e               op_w;
   op_e               op_q;
   rkind_e            kind;
   logic              start;
   logic [N_TOG-1:0]  flip;
   logic [N_TOG-1:0]  tog;
   logic [31:0]       arr_full;
   logic [DATA_W-1:0] arr_word;
   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] next_word;

   assign op_w = op_e'(op_i);

   // ---------------- operation-start detection ----------------
   always_ff @(posedge clk_i) begin
      if (!rst_ni) op_q <= OP_IDLE;
      else         op_q <= op_w;
   end

   assign start   = (op_w != op_q) && op_is_busy(op_w);
   assign ready_o = !op_is_busy(op_w);

   // ---------------- read classification ----------------
   fs_read_classify #(.SECT_W(SECT_W)) i_classify (
      .op_i       (op_w),
      .rd_bank_i  (rd_addr_i[BANK_BIT]),
      .rd_sect_i  (rd_addr_i[BANK_BIT-1 -: SECT_W]),
      .op_bank_i  (op_bank_i),
      .tgt_sect_i (tgt_sect_i),
      .kind_o     (kind)
   );

   // flip[0]: polled toggle; flip[1]: suspend-aware toggle
   assign flip[0] = rd_i && ((kind == RK_PROG) || (kind == RK_ERASE));
   assign flip[1] = rd_i && ((kind == RK_ERASE) || (kind == RK_SUSP));

   for (genvar t = 0; t < N_TOG; t++) begin : g_tog
      fs_toggle_bit i_tog (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .clr_i  (start),
         .flip_i (flip[t]),
         .cur_o  (tog[t])
      );
   end

   // ---------------- word assembly ----------------
   assign arr_full = array_word(32'(rd_addr_i));
   assign arr_word = arr_full[DATA_W-1:0];

   always_comb begin
      stat_word = '0;
      unique case (kind)
         RK_PROG: begin
            stat_word[POLL_BIT] = ~prog_msb_i;
            stat_word[TOG_BIT]  = tog[0];
            stat_word[TOG2_BIT] = tog[1];
         end
         RK_ERASE: begin
            stat_word[TOG_BIT]  = tog[0];
            stat_word[TOG2_BIT] = tog[1];
         end
         RK_SUSP: begin
            stat_word[POLL_BIT] = 1'b1;
            stat_word[TOG_BIT]  = 1'b1;
            stat_word[TOG2_BIT] = tog[1];
         end
         default: stat_word = '0;
      endcase
   end

   assign next_word = (kind == RK_DATA) ? arr_word : stat_word;

   // ---------------- output stage variant ----------------
   if (REG_OUT) begin : g_reg_out
      logic [DATA_W-1:0] rdata_q;

      always_ff @(posedge clk_i) begin
         if (!rst_ni)   rdata_q <= '0;
         else if (rd_i) rdata_q <= next_word;
      end
      assign rdata_o = rdata_q;

      // R2: idle reads return the array word one clock later
      p_idle_data_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (rd_i && op_w == OP_IDLE) |=>
            (rdata_o == DATA_W'(array_word(32'($past(rd_addr_i))))));

      // R3: reads from the idle bank return array data
      p_idle_bank_data_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (rd_i && rd_addr_i[BANK_BIT] != op_bank_i) |=>
            (rdata_o == DATA_W'(array_word(32'($past(rd_addr_i))))));

      // R4: program data polling returns the complement of the written bit
      p_prog_poll_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (rd_i && op_w == OP_PROG && rd_addr_i[BANK_BIT] == op_bank_i) |=>
            (rdata_o[POLL_BIT] == !$past(prog_msb_i)));

      // R5: erase status polls 0
      p_erase_poll_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (rd_i && op_w == OP_ERASE && rd_addr_i[BANK_BIT] == op_bank_i) |=>
            (rdata_o[POLL_BIT] == 1'b0));

      // R6: suspended sector reads show both fixed bits high
      p_susp_fixed_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (rd_i && op_w == OP_SUSP && rd_addr_i[BANK_BIT] == op_bank_i &&
          rd_addr_i[BANK_BIT-1 -: SECT_W] == tgt_sect_i) |=>
            (rdata_o[POLL_BIT] && rdata_o[TOG_BIT]));

      // R11: upper byte of any status word is zero
      p_status_upper_zero_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (rd_i && kind != RK_DATA) |=> (rdata_o[DATA_W-1:8] == '0));
   end else begin : g_comb_out
      assign rdata_o = next_word;
   end

   // R9: ready drops in the cycle a busy operation code is applied
   p_busy_ready_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_w == OP_ERASE) |-> !ready_o);

endmodule

// File: tb/test_flash_status_mux.sv
module test_flash_status_mux;

   logic        clk_i = 1'b0;
   logic        rst_ni;
   logic        rd_i;
   logic [11:0] rd_addr_i;
   logic [2:0]  op_i;
   logic        op_bank_i;
   logic [3:0]  tgt_sect_i;
   logic        prog_msb_i;
   logic [15:0] rdata_o;
   logic        ready_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // model state
   bit          m_t6, m_t2;
   logic [2:0]  m_prev;
   logic [15:0] m_out;
   string       m_tag;

   always #5 clk_i = ~clk_i;

   flash_status_mux i_flash_status_mux (
      .clk_i, .rst_ni, .rd_i, .rd_addr_i, .op_i, .op_bank_i,
      .tgt_sect_i, .prog_msb_i, .rdata_o, .ready_o
   );

   function automatic logic [15:0] exp_array(input logic [11:0] a);
      logic [31:0] m;
      m = (32'(a) * 32'd40503) ^ 32'h3C5A;
      return m[15:0];
   endfunction

   function automatic bit busy_code(input logic [2:0] op);
      return op == 3'd1 || op == 3'd2 || op == 3'd4;
   endfunction

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // One cycle: compare previous result, then apply new stimulus and advance model.
   task automatic step(input bit rd, input bit bank, input logic [3:0] sect,
                       input logic [6:0] off, input logic [2:0] op,
                       input bit obank, input logic [3:0] tsect, input bit msb);
      logic [11:0] a;
      bit start, e6, e2, inb, ins;
      logic [15:0] w;
      string tag;
      @(negedge clk_i);
      check(m_tag, rdata_o, m_out);
      a = {bank, sect, off};
      rd_i = rd; rd_addr_i = a; op_i = op; op_bank_i = obank;
      tgt_sect_i = tsect; prog_msb_i = msb;
      start = (op != m_prev) && busy_code(op);
      e6 = start ? 1'b0 : m_t6;
      e2 = start ? 1'b0 : m_t2;
      inb = (bank == obank);
      ins = (sect == tsect);
      w = exp_array(a);
      tag = (op == 3'd0) ? "R2" : (inb ? "R7" : "R3");
      if (inb && (op == 3'd1 || op == 3'd4)) begin
         w = 16'h0; w[7] = ~msb; w[6] = e6; w[2] = e2;
         tag = (op == 3'd4) ? "R8 R11" : "R4 R11";
         if (rd) m_t6 = ~e6; else m_t6 = e6;
         m_t2 = e2;
      end else if (inb && op == 3'd2) begin
         w = 16'h0; w[6] = e6; w[2] = e2;
         tag = "R5 R11";
         m_t6 = rd ? ~e6 : e6;
         m_t2 = rd ? ~e2 : e2;
      end else if (inb && op == 3'd3 && ins) begin
         w = 16'h0; w[7] = 1'b1; w[6] = 1'b1; w[2] = e2;
         tag = "R6 R11";
         m_t6 = e6;
         m_t2 = rd ? ~e2 : e2;
      end else begin
         m_t6 = e6; m_t2 = e2;
      end
      if (start && rd) tag = {tag, " R10"};
      m_prev = op;
      if (rd) begin
         m_out = w;
         m_tag = tag;
      end else begin
         m_tag = "R2 hold";
      end
      #1;
      check("R9 ready", {15'h0, ready_o}, {15'h0, !busy_code(op)});
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rst_ni = 1'b0; rd_i = 1'b0; rd_addr_i = '0; op_i = 3'd0;
      op_bank_i = 1'b0; tgt_sect_i = '0; prog_msb_i = 1'b0;
      m_t6 = 0; m_t2 = 0; m_prev = 3'd0; m_out = '0; m_tag = "R1";
      repeat (3) @(negedge clk_i);
      check("R1 reset rdata", rdata_o, 16'h0);
      check("R1 reset ready", {15'h0, ready_o}, 16'h1);
      rst_ni = 1'b1;

      // R2: idle array reads and hold
      step(1, 0, 4'd3, 7'd5, 3'd0, 0, 4'd0, 0);
      step(1, 1, 4'd15, 7'd127, 3'd0, 0, 4'd0, 0);
      step(0, 0, 4'd0, 7'd0, 3'd0, 0, 4'd0, 0);
      step(0, 0, 4'd0, 7'd0, 3'd0, 0, 4'd0, 0);
      // R4 program bank 0, R10 start with read, R3 other bank
      step(1, 0, 4'd1, 7'd9, 3'd1, 0, 4'd1, 1);
      step(1, 0, 4'd1, 7'd9, 3'd1, 0, 4'd1, 1);
      step(1, 1, 4'd1, 7'd9, 3'd1, 0, 4'd1, 1);
      step(1, 0, 4'd7, 7'd2, 3'd1, 0, 4'd1, 0);
      // R5 erase bank 1
      step(0, 0, 4'd0, 7'd0, 3'd2, 1, 4'd2, 0);
      step(1, 1, 4'd2, 7'd0, 3'd2, 1, 4'd2, 0);
      step(1, 1, 4'd5, 7'd1, 3'd2, 1, 4'd2, 0);
      step(1, 0, 4'd2, 7'd0, 3'd2, 1, 4'd2, 0);
      step(1, 1, 4'd2, 7'd3, 3'd2, 1, 4'd2, 0);
      // R6/R7 suspend on sector 2
      step(1, 1, 4'd2, 7'd4, 3'd3, 1, 4'd2, 0);
      step(1, 1, 4'd2, 7'd4, 3'd3, 1, 4'd2, 0);
      step(1, 1, 4'd3, 7'd4, 3'd3, 1, 4'd2, 0);
      step(1, 1, 4'd2, 7'd6, 3'd3, 1, 4'd2, 0);
      // R8 program during suspend
      step(1, 1, 4'd6, 7'd0, 3'd4, 1, 4'd6, 0);
      step(1, 1, 4'd2, 7'd0, 3'd4, 1, 4'd6, 0);
      step(1, 0, 4'd6, 7'd0, 3'd4, 1, 4'd6, 0);
      step(1, 1, 4'd6, 7'd8, 3'd0, 1, 4'd6, 0);

      // constrained random
      begin
         logic [2:0] op = 3'd0;
         bit ob = 1'b0;
         logic [3:0] ts = 4'd0;
         bit msb = 1'b0;
         for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 19) == 0) begin
               op  = 3'($urandom_range(0, 4));
               ob  = 1'($urandom_range(0, 1));
               ts  = 4'($urandom_range(0, 3));
               msb = 1'($urandom_range(0, 1));
            end
            step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                 4'($urandom_range(0, 3)), 7'($urandom_range(0, 127)),
                 op, ob, ts, msb);
         end
      end
      @(negedge clk_i);
      check(m_tag, rdata_o, m_out);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule